// File: doc/BRIEF.md
# Two-Channel Alarm Latch and Interrupt Controller

This block collects alarm conditions for a two-channel line interface and reports them through one active-low interrupt. Each channel takes a loss-of-signal level, an alarm-indication level, a bipolar-violation pulse and a waveform-overflow pulse. Two monitored clocks, transmit and reference, are watched for absence on the system clock. A power-up or reset event is also recorded. Each channel has an 8-bit status word, made of live bits, latched bits and an interrupt bit, and an 8-bit mask word. Both are reached over a small register port.

Software reads a status word to learn what happened and to clear that channel's latches. A mask bit set to 1 does two things: it holds the matching status bit at zero and it keeps that condition away from the interrupt. One mask bit of channel 1 is not a mask. It selects what the receive outputs carry during loss of signal: all ones or all zeros. At all other times the receive data passes straight through.

Top module: `alarm_irq_ctrl`

## Requirements
- R1: After reset, the channel 1 status is 0x02, the channel 2 status is 0x00, both mask words are 0x00 and `irq_n_o` is 0.
- R2: Register map, read combinationally on `rdata_o`: `addr_i` 0 is channel 1 status, 1 is channel 2 status, 2 is channel 1 mask, 3 is channel 2 mask. A write with `addr_i` 2 or 3 loads that mask. Status bit layout: 7 is live LOS, 6 is latched LOS, 5 is live AIS, 4 is latched AIS, 3 is latched BPV, 2 is latched overflow, 1 is the channel-specific latch (channel 1: reset event, channel 2: clock lost), 0 is the interrupt bit. Mask bit n controls status bit n.
- R3: Latched LOS and latched AIS set only on a rising edge of their input. A level held high does not set them again after a read.
- R4: Latched BPV sets on a `bpv_i` pulse only while that channel's `dec_en_i` is 1. Latched overflow sets on any `ovf_i` pulse.
- R5: A status read clears that channel's latched bits and interrupt bit at the clock edge ending the read cycle. A new event in that same cycle leaves its bit set.
- R6: A mask bit of 1 holds its status bit, live or latched, at 0, including a bit already set, and keeps the condition from raising the interrupt.
- R7: The channel 1 reset-event latch has no mask. Channel 1 mask bit 1 does not affect it and is cleared only by a read.
- R8: If either monitored clock shows no edge for `TIMEOUT` system cycles, the channel 2 clock-lost latch sets, and it keeps setting while the clock is absent. Channel 2 mask bit 1 masks it.
- R9: The interrupt bit of a channel sets whenever one of its unmasked latches is set by an event, or whenever a visible live bit (LOS or AIS after masking) changes value.
- R10: `irq_n_o` is 0 exactly when any latched bit or interrupt bit of either channel is 1.
- R11: During a channel's LOS, its `rpos_o`/`rneg_o` bits are forced to channel 1 mask bit 1 (1 gives all ones, 0 gives all zeros). Otherwise they follow `rpos_i`/`rneg_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset; also records a reset event |
| los_i | input | 2 | Loss-of-signal level per channel |
| ais_i | input | 2 | Alarm-indication level per channel |
| bpv_i | input | 2 | Bipolar-violation pulse per channel |
| ovf_i | input | 2 | Waveform-overflow pulse per channel |
| dec_en_i | input | 2 | Line-code decoder enabled, per channel |
| tx_clk_mon_i | input | 1 | Monitored transmit clock |
| ref_clk_mon_i | input | 1 | Monitored reference clock |
| addr_i | input | 2 | Register address |
| rd_i | input | 1 | Read strobe, one cycle |
| wr_i | input | 1 | Write strobe, one cycle |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data |
| irq_n_o | output | 1 | Active-low interrupt |
| rpos_i | input | 2 | Receive positive data in, per channel |
| rneg_i | input | 2 | Receive negative data in, per channel |
| rpos_o | output | 2 | Receive positive data out, per channel |
| rneg_o | output | 2 | Receive negative data out, per channel |

## Verification
The assertions assume that all alarm and strobe inputs are synchronous to `clk`, that violation and overflow pulses arrive as single-cycle strobes, and that reads and writes are never asserted together. The stimulus drives every input at the falling edge and never raises `rd_i` and `wr_i` in the same cycle. In the random phase it keeps both monitored clocks toggling every three system cycles, well inside the timeout, so clock loss shows up only in its directed test.

// File: rtl/alarm_irq_ctrl.sv
module alarm_irq_ctrl #(
  parameter int TIMEOUT = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] los_i,
  input  logic [1:0] ais_i,
  input  logic [1:0] bpv_i,
  input  logic [1:0] ovf_i,
  input  logic [1:0] dec_en_i,
  input  logic       tx_clk_mon_i,
  input  logic       ref_clk_mon_i,
  input  logic [1:0] addr_i,
  input  logic       rd_i,
  input  logic       wr_i,
  input  logic [7:0] wdata_i,
  output logic [7:0] rdata_o,
  output logic       irq_n_o,
  input  logic [1:0] rpos_i,
  input  logic [1:0] rneg_i,
  output logic [1:0] rpos_o,
  output logic [1:0] rneg_o
);
  localparam int CW = $clog2(TIMEOUT + 1);

  logic [1:0][7:0] mask, st;
  logic [1:0] lat_los, lat_ais, lat_bpv, lat_ovf, lat_sp, intb;
  logic [1:0] los_q, ais_q, losv_q, aisv_q;
  logic [1:0] mon_in, mon_lost;
  logic       clk_lost, aao;

  assign mon_in = {ref_clk_mon_i, tx_clk_mon_i};

  for (genvar k = 0; k < 2; k++) begin : g_mon
    logic [2:0]    sh;
    logic [CW-1:0] cnt;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        sh  <= '0;
        cnt <= '0;
      end else begin
        sh <= {sh[1:0], mon_in[k]};
        if (sh[2] ^ sh[1])           cnt <= '0;
        else if (cnt != CW'(TIMEOUT)) cnt <= cnt + 1'b1;
      end
    end
    assign mon_lost[k] = (cnt == CW'(TIMEOUT));
  end

  assign clk_lost = |mon_lost;

  logic [1:0] rd_st, losv, aisv;
  logic [1:0] ev_los, ev_ais, ev_bpv, ev_ovf, ev_sp;
  logic [1:0] m_los, m_ais, m_bpv, m_ovf, m_sp, chg;

  assign rd_st  = {rd_i && addr_i == 2'd1, rd_i && addr_i == 2'd0};
  assign m_los  = {mask[1][6], mask[0][6]};
  assign m_ais  = {mask[1][4], mask[0][4]};
  assign m_bpv  = {mask[1][3], mask[0][3]};
  assign m_ovf  = {mask[1][2], mask[0][2]};
  assign m_sp   = {mask[1][1], 1'b0};
  assign losv   = los_i & ~{mask[1][7], mask[0][7]};
  assign aisv   = ais_i & ~{mask[1][5], mask[0][5]};
  assign ev_los = los_i & ~los_q;
  assign ev_ais = ais_i & ~ais_q;
  assign ev_bpv = bpv_i & dec_en_i;
  assign ev_ovf = ovf_i;
  assign ev_sp  = {clk_lost, 1'b0};
  assign chg    = (losv ^ losv_q) | (aisv ^ aisv_q) | (ev_los & ~m_los) | (ev_ais & ~m_ais)
                | (ev_bpv & ~m_bpv) | (ev_ovf & ~m_ovf) | (ev_sp & ~m_sp);

  function automatic logic nxt(input logic cur, input logic ev, input logic m, input logic clr);
    return m ? 1'b0 : (ev ? 1'b1 : (clr ? 1'b0 : cur));
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask    <= '0;
      lat_los <= '0;
      lat_ais <= '0;
      lat_bpv <= '0;
      lat_ovf <= '0;
      lat_sp  <= 2'b01;
      intb    <= '0;
      los_q   <= '0;
      ais_q   <= '0;
      losv_q  <= '0;
      aisv_q  <= '0;
    end else begin
      for (int c = 0; c < 2; c++) begin
        lat_los[c] <= nxt(lat_los[c], ev_los[c], m_los[c], rd_st[c]);
        lat_ais[c] <= nxt(lat_ais[c], ev_ais[c], m_ais[c], rd_st[c]);
        lat_bpv[c] <= nxt(lat_bpv[c], ev_bpv[c], m_bpv[c], rd_st[c]);
        lat_ovf[c] <= nxt(lat_ovf[c], ev_ovf[c], m_ovf[c], rd_st[c]);
        lat_sp[c]  <= nxt(lat_sp[c],  ev_sp[c],  m_sp[c],  rd_st[c]);
        intb[c]    <= nxt(intb[c],    chg[c],    mask[c][0], rd_st[c]);
      end
      if (wr_i && addr_i[1]) mask[addr_i[0]] <= wdata_i;
      los_q  <= los_i;
      ais_q  <= ais_i;
      losv_q <= losv;
      aisv_q <= aisv;
    end
  end

  always_comb begin
    for (int c = 0; c < 2; c++)
      st[c] = {losv[c], lat_los[c], aisv[c], lat_ais[c], lat_bpv[c], lat_ovf[c], lat_sp[c], intb[c]};
  end

  assign rdata_o = addr_i[1] ? mask[addr_i[0]] : st[addr_i[0]];
  assign irq_n_o = ~|{lat_los, lat_ais, lat_bpv, lat_ovf, lat_sp, intb};
  assign aao     = mask[0][1];
  assign rpos_o  = (los_i & {2{aao}}) | (~los_i & rpos_i);
  assign rneg_o  = (los_i & {2{aao}}) | (~los_i & rneg_i);
endmodule

// File: rtl/alarm_irq_ctrl_chk.sv
module alarm_irq_ctrl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       rd_i,
  input logic [1:0] addr_i,
  input logic       ais0,
  input logic       ovf0,
  input logic       dec0,
  input logic       mbpv0,
  input logic       lat_ais0,
  input logic       lat_bpv0,
  input logic       lat_ovf0,
  input logic       lat_rst0,
  input logic       int0,
  input logic       irq_n
);
  logic rd0;
  assign rd0 = rd_i && addr_i == 2'd0;

  assert_ais_edge_only_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $past(ais0, 2) && $past(ais0) && $past(rd0) |-> !lat_ais0);

  assert_bpv_needs_decoder_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !dec0 && !lat_bpv0 |=> !lat_bpv0);

  assert_read_clears_R5: assert property (@(posedge clk) disable iff (!rst_n)
    rd0 && !ovf0 |=> !lat_ovf0);

  assert_masked_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
    mbpv0 && $past(mbpv0) |-> !lat_bpv0);

  assert_reset_latch_held_R7: assert property (@(posedge clk) disable iff (!rst_n)
    lat_rst0 && !rd0 |=> lat_rst0);

  assert_int_drives_irq_R10: assert property (@(posedge clk) disable iff (!rst_n)
    int0 |-> !irq_n);
endmodule

bind alarm_irq_ctrl alarm_irq_ctrl_chk chk_i (
  .clk      (clk),
  .rst_n    (rst_n),
  .rd_i     (rd_i),
  .addr_i   (addr_i),
  .ais0     (ais_i[0]),
  .ovf0     (ovf_i[0]),
  .dec0     (dec_en_i[0]),
  .mbpv0    (mask[0][3]),
  .lat_ais0 (lat_ais[0]),
  .lat_bpv0 (lat_bpv[0]),
  .lat_ovf0 (lat_ovf[0]),
  .lat_rst0 (lat_sp[0]),
  .int0     (intb[0]),
  .irq_n    (irq_n_o)
);

// File: tb/alarm_irq_ctrl_tb_top.sv
module alarm_irq_ctrl_tb_top;
  logic clk = 0, rst_n = 0;
  logic [1:0] los = 0, ais = 0, bpv = 0, ovf = 0, dec_en = 0, addr = 0, rpos_in = 0, rneg_in = 0;
  logic tx_mon = 0, ref_mon = 0, tx_run = 1, ref_run = 1, rd = 0, wr = 0;
  logic [7:0] wdata = 0, rdata;
  logic irq_n;
  logic [1:0] rpos_out, rneg_out;
  int checks = 0, errors = 0;

  always #10 clk = ~clk;

  alarm_irq_ctrl #(.TIMEOUT(16)) dut_i (
    .clk(clk), .rst_n(rst_n), .los_i(los), .ais_i(ais), .bpv_i(bpv), .ovf_i(ovf),
    .dec_en_i(dec_en), .tx_clk_mon_i(tx_mon), .ref_clk_mon_i(ref_mon),
    .addr_i(addr), .rd_i(rd), .wr_i(wr), .wdata_i(wdata), .rdata_o(rdata),
    .irq_n_o(irq_n), .rpos_i(rpos_in), .rneg_i(rneg_in), .rpos_o(rpos_out), .rneg_o(rneg_out));

  initial forever begin
    repeat (3) @(negedge clk);
    if (tx_run)  tx_mon  = ~tx_mon;
    if (ref_run) ref_mon = ~ref_mon;
  end

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) begin @(negedge clk); @(posedge clk); #1; end
  endtask

  task automatic rdreg(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk); addr = a; rd = 1; #2 d = rdata;
    @(posedge clk); #1 rd = 0;
  endtask

  task automatic rdchk(input logic [1:0] a, input logic [7:0] exp, input string req);
    logic [7:0] d;
    rdreg(a, d);
    check(req, d, exp);
  endtask

  task automatic wrreg(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk); addr = a; wdata = d; wr = 1;
    @(posedge clk); #1 wr = 0;
  endtask

  task automatic pulse_bpv(input logic [1:0] v);
    @(negedge clk); bpv = v; @(posedge clk); #1 bpv = 0;
  endtask

  task automatic pulse_ovf(input logic [1:0] v);
    @(negedge clk); ovf = v; @(posedge clk); #1 ovf = 0;
  endtask

  task automatic peek_irq(input logic exp, input string req);
    @(negedge clk); #2 check(req, {7'd0, irq_n}, {7'd0, exp});
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 0; los = 0; ais = 0; bpv = 0; ovf = 0; rd = 0; wr = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
  endtask

  // reference model, built from the requirements
  logic [1:0] m_llos, m_lais, m_lbpv, m_lovf, m_lsp, m_int, m_losq, m_aisq, m_losvq, m_aisvq;
  logic [7:0] m_mask [2];

  function automatic logic [7:0] exp_st(input int c);
    return {los[c] & ~m_mask[c][7], m_llos[c], ais[c] & ~m_mask[c][5], m_lais[c],
            m_lbpv[c], m_lovf[c], m_lsp[c], m_int[c]};
  endfunction

  function automatic logic upd(input logic cur, input logic ev, input logic m, input logic clr);
    if (m) return 1'b0;
    if (ev) return 1'b1;
    if (clr) return 1'b0;
    return cur;
  endfunction

  task automatic model_step();
    for (int c = 0; c < 2; c++) begin
      logic rdc, el, ea, eb, eo, lv, av, ch;
      rdc = rd && addr == 2'(c);
      el = los[c] & ~m_losq[c];
      ea = ais[c] & ~m_aisq[c];
      eb = bpv[c] & dec_en[c];
      eo = ovf[c];
      lv = los[c] & ~m_mask[c][7];
      av = ais[c] & ~m_mask[c][5];
      ch = (lv != m_losvq[c]) | (av != m_aisvq[c]) | (el & ~m_mask[c][6]) | (ea & ~m_mask[c][4])
         | (eb & ~m_mask[c][3]) | (eo & ~m_mask[c][2]);
      m_llos[c] = upd(m_llos[c], el, m_mask[c][6], rdc);
      m_lais[c] = upd(m_lais[c], ea, m_mask[c][4], rdc);
      m_lbpv[c] = upd(m_lbpv[c], eb, m_mask[c][3], rdc);
      m_lovf[c] = upd(m_lovf[c], eo, m_mask[c][2], rdc);
      m_lsp[c]  = upd(m_lsp[c], 1'b0, (c == 1) ? m_mask[1][1] : 1'b0, rdc);
      m_int[c]  = upd(m_int[c], ch, m_mask[c][0], rdc);
      m_losvq[c] = lv;
      m_aisvq[c] = av;
    end
    if (wr && addr[1]) m_mask[addr[0]] = wdata;
    m_losq = los;
    m_aisq = ais;
  endtask

  initial begin
    #(20 * 150000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [7:0] d;
    void'($urandom(32'd2024));
    do_reset();
    // R1 reset state
    peek_irq(1'b0, "R1 irq after reset");
    rdchk(2'd2, 8'h00, "R1 mask ch1");
    rdchk(2'd3, 8'h00, "R1 mask ch2");
    rdchk(2'd1, 8'h00, "R1 status ch2");
    rdchk(2'd0, 8'h02, "R1 status ch1");
    rdchk(2'd0, 8'h00, "R5 reset latch cleared by read");
    peek_irq(1'b1, "R10 irq idle");

    // random phase against the model
    do_reset();
    m_llos = 0; m_lais = 0; m_lbpv = 0; m_lovf = 0; m_lsp = 2'b01; m_int = 0;
    m_losq = 0; m_aisq = 0; m_losvq = 0; m_aisvq = 0; m_mask[0] = 0; m_mask[1] = 0;
    for (int i = 0; i < 4000; i++) begin
      @(negedge clk);
      for (int c = 0; c < 2; c++) begin
        if ($urandom % 20 == 0) los[c] = ~los[c];
        if ($urandom % 20 == 0) ais[c] = ~ais[c];
        if ($urandom % 50 == 0) dec_en[c] = ~dec_en[c];
        bpv[c] = ($urandom % 8 == 0);
        ovf[c] = ($urandom % 12 == 0);
      end
      rd = ($urandom % 5 == 0);
      wr = !rd && ($urandom % 30 == 0);
      addr = 2'($urandom);
      wdata = 8'($urandom) & 8'($urandom);
      rpos_in = 2'($urandom);
      rneg_in = 2'($urandom);
      #2;
      check("R2 readback", rdata, addr[1] ? m_mask[addr[0]] : exp_st(int'(addr[0])));
      check("R10 irq", {7'd0, irq_n},
            {7'd0, ~|{m_llos, m_lais, m_lbpv, m_lovf, m_lsp, m_int}});
      check("R11 rpos", {6'd0, rpos_out}, {6'd0, (los & {2{m_mask[0][1]}}) | (~los & rpos_in)});
      check("R11 rneg", {6'd0, rneg_out}, {6'd0, (los & {2{m_mask[0][1]}}) | (~los & rneg_in)});
      model_step();
    end
    @(negedge clk);
    los = 0; ais = 0; bpv = 0; ovf = 0; rd = 0; wr = 0; rpos_in = 0; rneg_in = 0; dec_en = 0;

    // directed corners
    do_reset();
    rdchk(2'd0, 8'h02, "R1 status ch1 again");
    ais[0] = 1;
    idle(2);
    rdchk(2'd0, 8'h31, "R3 AIS rise latched, R9 int set");
    rdchk(2'd0, 8'h20, "R3 AIS level does not relatch");
    ais[0] = 0;
    idle(1);
    rdchk(2'd0, 8'h01, "R9 live AIS fall sets int");
    rdchk(2'd0, 8'h00, "R5 clear");

    los[1] = 1;
    idle(1);
    @(negedge clk); #2 check("R11 zeros during LOS", {4'd0, rpos_out, rneg_out}, 8'h00);
    wrreg(2'd2, 8'h02);
    @(negedge clk); #2 check("R11 ones during LOS", {4'd0, rpos_out, rneg_out}, 8'h0A);
    rdchk(2'd1, 8'hC1, "R3 LOS latched ch2");
    los[1] = 0; rpos_in = 2'b11; rneg_in = 2'b01;
    @(negedge clk); #2 check("R11 passthrough", {4'd0, rpos_out, rneg_out}, 8'h0D);
    rdchk(2'd1, 8'h01, "R9 live LOS fall");
    rdchk(2'd1, 8'h00, "R5 clear ch2");
    wrreg(2'd2, 8'h00);

    dec_en = 2'b00;
    pulse_bpv(2'b01);
    rdchk(2'd0, 8'h00, "R4 BPV ignored with decoder off");
    dec_en = 2'b11;
    pulse_bpv(2'b01);
    rdchk(2'd0, 8'h09, "R4 BPV latched with decoder on");
    pulse_ovf(2'b10);
    rdchk(2'd1, 8'h05, "R4 overflow latched ch2");

    @(negedge clk); addr = 0; rd = 1; bpv = 2'b01; #2 d = rdata;
    @(posedge clk); #1 rd = 0; bpv = 0;
    check("R5 read in event cycle data", d, 8'h00);
    rdchk(2'd0, 8'h09, "R5 event survives read");
    rdchk(2'd0, 8'h00, "R5 clear after");

    wrreg(2'd2, 8'h08);
    pulse_bpv(2'b01);
    idle(1);
    peek_irq(1'b1, "R6 masked BPV no irq");
    rdchk(2'd0, 8'h00, "R6 masked BPV stays zero");
    wrreg(2'd3, 8'hC0);
    los[1] = 1;
    idle(2);
    rdchk(2'd1, 8'h00, "R6 masked live and latched LOS");
    peek_irq(1'b1, "R6 masked LOS no irq");
    los[1] = 0;
    wrreg(2'd3, 8'h00);
    pulse_ovf(2'b01);
    peek_irq(1'b0, "R10 overflow raises irq");
    wrreg(2'd2, 8'h0D);
    idle(1);
    peek_irq(1'b1, "R6 mask clears set latch");
    rdchk(2'd0, 8'h00, "R6 status after late mask");
    wrreg(2'd2, 8'h00);

    tx_run = 0;
    idle(40);
    peek_irq(1'b0, "R8 clock loss irq");
    rdchk(2'd1, 8'h03, "R8 clock lost latched");
    tx_run = 1;
    idle(15);
    rdchk(2'd1, 8'h03, "R8 latched while absent until read");
    rdchk(2'd1, 8'h00, "R8 cleared after recovery");
    wrreg(2'd3, 8'h02);
    ref_run = 0;
    idle(40);
    rdchk(2'd1, 8'h00, "R8 masked clock lost");
    peek_irq(1'b1, "R8 masked no irq");
    ref_run = 1;
    idle(15);
    wrreg(2'd3, 8'h00);

    do_reset();
    wrreg(2'd2, 8'hFF);
    idle(1);
    peek_irq(1'b0, "R7 reset latch drives irq under mask");
    rdchk(2'd0, 8'h02, "R7 reset latch unmaskable");
    rdchk(2'd0, 8'h00, "R7 read clears reset latch");
    peek_irq(1'b1, "R10 idle after clear");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule